// File: doc/BRIEF.md
# Halt and Wake-Up Controller

This block sits beside a small processor core and governs its low-power sleep state. When the core issues its sleep instruction strobe, the controller gates the core's system clock off, records that a power-down took place and clears the watchdog time-out indication. The core's RAM, registers and port pins are left as they are; only the clock stops.

While asleep, the controller watches four wake sources. These are an external reset request, a watchdog overflow, a fresh interrupt request, and a falling edge on any port pin whose wake enable is set. When one of them fires, the controller records which source woke the core. For an interrupt wake it also decides whether the core should vector to the interrupt or simply continue at the instruction after the sleep instruction. It then holds the clock off for a fixed stabilisation period counted on the free-running reference clock `clk`. Only after that does it release the clock and raise a one-cycle ready pulse.

All inputs are taken to be synchronous to `clk`. The asynchronous active-low reset is the power-up reset. Its release is synchronised inside the block, so the block leaves reset two `clk` edges after `rst_n` rises.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After power-up reset the block is running: `sys_clk_en`=1, `power_down_flag`=0, `wdt_timeout_flag`=0, `take_irq`=0, `wake_src`=0, `ready`=0.
- R2: A `halt_strobe` while running makes `sys_clk_en` 0 from the next cycle, sets `power_down_flag` and clears `wdt_timeout_flag` in that same cycle.
- R3: A `wdt_clear` while running, with no `halt_strobe` and no `wdt_ovf` in that cycle, clears both `power_down_flag` and `wdt_timeout_flag` on the next cycle.
- R4: While halted, a 1-to-0 transition on a `port_in` bit whose `port_wake_en` bit is 1 wakes the block with `wake_src`=0 (port) and `take_irq`=0. The same transition on a pin whose enable is 0 does not wake it.
- R5: While halted, a 0-to-1 transition of an `irq_req` bit wakes the block with `wake_src`=1 (interrupt). `take_irq` is 1 when that bit's `irq_en` is 1 and `stack_full` is 0 in the wake cycle.
- R6: An interrupt wake whose rising request has `irq_en`=0, or that occurs with `stack_full`=1, still wakes the block but gives `take_irq`=0.
- R7: An `irq_req` bit that is already 1 in the cycle of `halt_strobe` cannot wake the block for the rest of that halt, even if it falls and rises again.
- R8: `wdt_ovf` sets `wdt_timeout_flag` (taking precedence over `wdt_clear`). While halted it also wakes the block with `wake_src`=2 (watchdog) and leaves `power_down_flag` at 1.
- R9: While halted, `ext_rst` wakes the block with `wake_src`=3 (external reset) and `take_irq`=0.
- R10: After the wake-event cycle, `sys_clk_en` stays 0 for exactly `STAB_CYCLES` (default 1024) further cycles and then goes to 1. `ready` is 1 only in the first cycle in which `sys_clk_en` is 1 again.
- R11: When several wake sources fire in the same cycle, the recorded source follows the order external reset, watchdog overflow, interrupt, port pin.
- R12: Wake sources and `halt_strobe` arriving during the stabilisation period change neither `wake_src`, `take_irq` nor the release time. `ext_rst` while running has no effect on `sys_clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| halt_strobe | input | 1 | One-cycle pulse: sleep instruction executed |
| wdt_clear | input | 1 | One-cycle pulse: watchdog clear instruction executed |
| wdt_ovf | input | 1 | One-cycle pulse: watchdog counter overflowed |
| ext_rst | input | 1 | External reset request (wake source) |
| irq_req | input | N_IRQ | Interrupt request flags |
| irq_en | input | N_IRQ | Per-interrupt enables |
| stack_full | input | 1 | Core call stack is full |
| port_in | input | N_PIN | Port pin levels |
| port_wake_en | input | N_PIN | Per-pin wake enables |
| sys_clk_en | output | 1 | Core system-clock gate enable |
| power_down_flag | output | 1 | Set by sleep, cleared by reset or watchdog clear |
| wdt_timeout_flag | output | 1 | Set by watchdog overflow, cleared by sleep or watchdog clear |
| take_irq | output | 1 | 1: vector to interrupt on resume; 0: continue at next instruction |
| wake_src | output | 2 | Last wake cause: 0 port, 1 interrupt, 2 watchdog, 3 external reset |
| ready | output | 1 | One-cycle pulse when the clock is released after stabilisation |

## Verification
On every cycle, the assertions check the effect of the sleep strobe and of the watchdog inputs on the two flags. They also check that `ready` is a single pulse tied exactly to the clock re-enabling, that the stabilisation count stays in range, that the recorded cause does not move during stabilisation, and that an external reset while asleep wins the arbitration. The length of the stabilisation window, the choice between vectoring and continuing, and the blocking of interrupts already pending at entry can only be shown by the bench's scenarios. The same holds for disabled port pins not waking the block and for the full priority order among simultaneous wake sources.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

  typedef enum logic [1:0] {
    HW_RUN  = 2'd0,
    HW_HALT = 2'd1,
    HW_STAB = 2'd2
  } hw_state_e;

  typedef enum logic [1:0] {
    WK_PORT = 2'd0,
    WK_IRQ  = 2'd1,
    WK_WDT  = 2'd2,
    WK_EXT  = 2'd3
  } wake_src_e;

endpackage

// File: rtl/hw_edge_detect.sv
module hw_edge_detect #(
  parameter int WIDTH   = 1,
  parameter bit FALLING = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] edge_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev_q & ~sig_i;
    end else begin : g_rise
      assign edge_o = sig_i & ~prev_q;
    end
  endgenerate

endmodule

// File: rtl/hw_stab_timer.sv
module hw_stab_timer #(
  parameter int CYCLES = 1024,
  parameter int CW     = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = run_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_comb begin
    if (!run_i || done_o) cnt_d = '0;
    else                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/hw_wake_arbiter.sv
module hw_wake_arbiter
  import halt_wake_pkg::*;
#(
  parameter int N_IRQ = 3
) (
  input  logic             armed_i,
  input  logic             ext_i,
  input  logic             wdt_i,
  input  logic [N_IRQ-1:0] irq_rise_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             stack_full_i,
  input  logic             port_any_i,
  output logic             wake_o,
  output wake_src_e        src_o,
  output logic             take_irq_o
);

  logic irq_any;
  logic irq_vectorable;

  assign irq_any        = |irq_rise_i;
  assign irq_vectorable = |(irq_rise_i & irq_en_i) && !stack_full_i;

  always_comb begin
    wake_o     = 1'b0;
    src_o      = WK_PORT;
    take_irq_o = 1'b0;
    if (armed_i) begin
      if (ext_i) begin
        wake_o = 1'b1;
        src_o  = WK_EXT;
      end else if (wdt_i) begin
        wake_o = 1'b1;
        src_o  = WK_WDT;
      end else if (irq_any) begin
        wake_o     = 1'b1;
        src_o      = WK_IRQ;
        take_irq_o = irq_vectorable;
      end else if (port_any_i) begin
        wake_o = 1'b1;
        src_o  = WK_PORT;
      end
    end
  end

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
#(
  parameter int N_IRQ       = 3,
  parameter int N_PIN       = 8,
  parameter int STAB_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_strobe,
  input  logic             wdt_clear,
  input  logic             wdt_ovf,
  input  logic             ext_rst,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             stack_full,
  input  logic [N_PIN-1:0] port_in,
  input  logic [N_PIN-1:0] port_wake_en,
  output logic             sys_clk_en,
  output logic             power_down_flag,
  output logic             wdt_timeout_flag,
  output logic             take_irq,
  output logic [1:0]       wake_src,
  output logic             ready
);

  localparam int CW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  hw_state_e        state_q, state_d;
  logic             pdf_q, pdf_d;
  logic             tmo_q, tmo_d;
  logic [N_IRQ-1:0] irq_snap_q;
  wake_src_e        src_q;
  logic             take_q;
  logic             ready_q;

  logic             running, halted, stabilising;
  logic             enter_halt;
  logic [N_IRQ-1:0] irq_rise_raw, irq_rise;
  logic [N_PIN-1:0] port_fall;
  logic             wake;
  wake_src_e        wake_src_nx;
  logic             take_nx;
  logic             stab_done;
  logic [CW-1:0]    stab_cnt;

  assign running     = (state_q == HW_RUN);
  assign halted      = (state_q == HW_HALT);
  assign stabilising = (state_q == HW_STAB);
  assign enter_halt  = running && halt_strobe;

  hw_edge_detect #(.WIDTH(N_IRQ), .FALLING(1'b0)) u_irq_edge (
    .clk(clk), .rst_n(rst_sync_n), .sig_i(irq_req), .edge_o(irq_rise_raw)
  );

  hw_edge_detect #(.WIDTH(N_PIN), .FALLING(1'b1)) u_port_edge (
    .clk(clk), .rst_n(rst_sync_n), .sig_i(port_in), .edge_o(port_fall)
  );

  // requests already pending at entry are masked for the whole halt
  assign irq_rise = irq_rise_raw & ~irq_snap_q;

  hw_wake_arbiter #(.N_IRQ(N_IRQ)) u_arb (
    .armed_i     (halted),
    .ext_i       (ext_rst),
    .wdt_i       (wdt_ovf),
    .irq_rise_i  (irq_rise),
    .irq_en_i    (irq_en),
    .stack_full_i(stack_full),
    .port_any_i  (|(port_fall & port_wake_en)),
    .wake_o      (wake),
    .src_o       (wake_src_nx),
    .take_irq_o  (take_nx)
  );

  hw_stab_timer #(.CYCLES(STAB_CYCLES), .CW(CW)) u_stab (
    .clk(clk), .rst_n(rst_sync_n), .run_i(stabilising),
    .done_o(stab_done), .cnt_o(stab_cnt)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HW_RUN:  if (halt_strobe) state_d = HW_HALT;
      HW_HALT: if (wake)        state_d = HW_STAB;
      HW_STAB: if (stab_done)   state_d = HW_RUN;
      default:                  state_d = HW_RUN;
    endcase
  end

  always_comb begin
    pdf_d = pdf_q;
    tmo_d = tmo_q;
    if (enter_halt) begin
      pdf_d = 1'b1;
      tmo_d = 1'b0;
    end else begin
      if (running && wdt_clear) begin
        pdf_d = 1'b0;
        tmo_d = 1'b0;
      end
      if (wdt_ovf) tmo_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= HW_RUN;
      pdf_q   <= 1'b0;
      tmo_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pdf_q   <= pdf_d;
      tmo_q   <= tmo_d;
      ready_q <= stab_done;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     irq_snap_q <= '0;
    else if (enter_halt) irq_snap_q <= irq_req;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      src_q  <= WK_PORT;
      take_q <= 1'b0;
    end else if (wake) begin
      src_q  <= wake_src_nx;
      take_q <= take_nx;
    end
  end

  assign sys_clk_en       = running;
  assign power_down_flag  = pdf_q;
  assign wdt_timeout_flag = tmo_q;
  assign take_irq         = take_q;
  assign wake_src         = src_q;
  assign ready            = ready_q;

endmodule

// File: rtl/halt_wake_ctrl_chk.sv
module halt_wake_ctrl_chk
  import halt_wake_pkg::*;
#(
  parameter int STAB_CYCLES = 1024,
  parameter int CW          = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            halt_strobe,
  input logic            wdt_clear,
  input logic            wdt_ovf,
  input logic            ext_rst,
  input logic            sys_clk_en,
  input logic            power_down_flag,
  input logic            wdt_timeout_flag,
  input logic [1:0]      wake_src,
  input logic            ready,
  input hw_state_e       state_q,
  input logic [CW-1:0]   stab_cnt
);

  // R2: sleep strobe gates the clock and sets the flags
  a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sys_clk_en && halt_strobe) |=> (!sys_clk_en && power_down_flag && !wdt_timeout_flag));

  // R3: watchdog clear while running clears both flags
  a_r3_wdt_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sys_clk_en && wdt_clear && !halt_strobe && !wdt_ovf) |=> (!power_down_flag && !wdt_timeout_flag));

  // R8: overflow sets the time-out flag
  a_r8_timeout_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wdt_ovf && !(sys_clk_en && halt_strobe)) |=> wdt_timeout_flag);

  // R10: ready is a single pulse
  a_r10_ready_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready |=> !ready);

  // R10: ready coincides with clock release
  a_r10_ready_on_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sys_clk_en) |-> ready);

  a_r10_ready_needs_clock: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready |-> (sys_clk_en && !$past(sys_clk_en)));

  // R11: external reset wins while halted
  a_r11_ext_first: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == HW_HALT && ext_rst) |=> (wake_src == 2'd3));

  // R12: recorded cause frozen during stabilisation
  a_r12_cause_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == HW_STAB && $past(state_q) == HW_STAB) |-> $stable(wake_src));

  // R10: counter range
  always @(posedge clk) begin
    if (rst_sync_n) begin
      a_r10_cnt_range: assert (int'(stab_cnt) < STAB_CYCLES);
    end
  end

endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk #(.STAB_CYCLES(STAB_CYCLES), .CW(CW)) u_chk (
  .clk             (clk),
  .rst_sync_n      (rst_sync_n),
  .halt_strobe     (halt_strobe),
  .wdt_clear       (wdt_clear),
  .wdt_ovf         (wdt_ovf),
  .ext_rst         (ext_rst),
  .sys_clk_en      (sys_clk_en),
  .power_down_flag (power_down_flag),
  .wdt_timeout_flag(wdt_timeout_flag),
  .wake_src        (wake_src),
  .ready           (ready),
  .state_q         (state_q),
  .stab_cnt        (stab_cnt)
);

// File: tb/test_halt_wake_ctrl.sv
`timescale 1ns/1ps
module test_halt_wake_ctrl;

  localparam int NI    = 3;
  localparam int NP    = 8;
  localparam int DELAY = 1024;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          halt_strobe, wdt_clear, wdt_ovf, ext_rst, stack_full;
  logic [NI-1:0] irq_req, irq_en;
  logic [NP-1:0] port_in, port_wake_en;
  logic          sys_clk_en, power_down_flag, wdt_timeout_flag, take_irq, ready;
  logic [1:0]    wake_src;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  halt_wake_ctrl #(.N_IRQ(NI), .N_PIN(NP), .STAB_CYCLES(DELAY)) i_halt_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_strobe(halt_strobe), .wdt_clear(wdt_clear),
    .wdt_ovf(wdt_ovf), .ext_rst(ext_rst), .irq_req(irq_req), .irq_en(irq_en),
    .stack_full(stack_full), .port_in(port_in), .port_wake_en(port_wake_en),
    .sys_clk_en(sys_clk_en), .power_down_flag(power_down_flag),
    .wdt_timeout_flag(wdt_timeout_flag), .take_irq(take_irq),
    .wake_src(wake_src), .ready(ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    halt_strobe = 0; wdt_clear = 0; wdt_ovf = 0; ext_rst = 0;
    irq_req = '0; port_in = '1;
  endtask

  task automatic do_halt(input string req);
    @(negedge clk); halt_strobe = 1;
    @(negedge clk); halt_strobe = 0;
    chk(req, "clock gated after sleep", int'(sys_clk_en), 0);
  endtask

  // Called right after the negedge where the wake stimulus was driven.
  task automatic wait_wake(input string req, input int src, input int take, input int inject_at);
    bit bad = 0;
    for (int k = 1; k <= DELAY; k++) begin
      @(negedge clk);
      if (k == 1) quiet();
      if (k == inject_at) begin ext_rst = 1; irq_req = '1; halt_strobe = 1; port_in = '0; end
      if (k == inject_at + 1) quiet();
      if (sys_clk_en !== 1'b0 || ready !== 1'b0) bad = 1;
    end
    chk(req, "clock held off through stabilisation", int'(bad), 0);
    @(negedge clk);
    quiet();
    chk(req, "clock released", int'(sys_clk_en), 1);
    chk(req, "ready pulse", int'(ready), 1);
    chk(req, "wake source", int'(wake_src), src);
    chk(req, "take_irq", int'(take_irq), take);
    @(negedge clk);
    chk(req, "ready drops", int'(ready), 0);
  endtask

  task automatic stays_halted(input string req, input int cycles);
    bit bad = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (sys_clk_en !== 1'b0) bad = 1;
    end
    chk(req, "no wake", int'(bad), 0);
  endtask

  task automatic t_reset();
    quiet(); irq_en = '0; port_wake_en = '0; stack_full = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "sys_clk_en", int'(sys_clk_en), 1);
    chk("R1", "power_down_flag", int'(power_down_flag), 0);
    chk("R1", "wdt_timeout_flag", int'(wdt_timeout_flag), 0);
    chk("R1", "take_irq", int'(take_irq), 0);
    chk("R1", "wake_src", int'(wake_src), 0);
    chk("R1", "ready", int'(ready), 0);
  endtask

  task automatic t_flags();
    // R8: overflow while running sets time-out
    @(negedge clk); wdt_ovf = 1;
    @(negedge clk); wdt_ovf = 0;
    chk("R8", "timeout set while running", int'(wdt_timeout_flag), 1);
    // R12: external reset while running does nothing to the clock
    @(negedge clk); ext_rst = 1;
    @(negedge clk); ext_rst = 0;
    chk("R12", "ext_rst while running", int'(sys_clk_en), 1);
    do_halt("R2");
    chk("R2", "power_down_flag set", int'(power_down_flag), 1);
    chk("R2", "timeout cleared", int'(wdt_timeout_flag), 0);
    // R12: second strobe while halted ignored
    @(negedge clk); halt_strobe = 1;
    @(negedge clk); halt_strobe = 0;
    chk("R12", "strobe while halted", int'(sys_clk_en), 0);
    @(negedge clk); ext_rst = 1;
    wait_wake("R9", 3, 0, 0);
    chk("R9", "power_down_flag kept", int'(power_down_flag), 1);
    @(negedge clk); wdt_clear = 1;
    @(negedge clk); wdt_clear = 0;
    chk("R3", "power_down_flag cleared", int'(power_down_flag), 0);
    chk("R3", "timeout cleared", int'(wdt_timeout_flag), 0);
  endtask

  task automatic t_port();
    port_wake_en = 8'b0000_0100;
    do_halt("R4");
    @(negedge clk); port_in = 8'b1111_1101;   // disabled pin 1 falls
    stays_halted("R4", 5);
    port_in = '1;
    @(negedge clk); port_in = 8'b1111_1011;   // enabled pin 2 falls
    wait_wake("R4", 0, 0, 0);
    chk("R4", "timeout still clear", int'(wdt_timeout_flag), 0);
  endtask

  task automatic t_irq();
    irq_en = 3'b011; stack_full = 0;
    do_halt("R5");
    @(negedge clk); irq_req = 3'b001;
    wait_wake("R5", 1, 1, 0);
    do_halt("R6");
    @(negedge clk); irq_req = 3'b100;          // disabled interrupt
    wait_wake("R6", 1, 0, 0);
    do_halt("R6");
    @(negedge clk); irq_req = 3'b010; stack_full = 1;
    wait_wake("R6", 1, 0, 0);
    stack_full = 0;
  endtask

  task automatic t_pending();
    @(negedge clk); irq_req = 3'b001; halt_strobe = 1;
    @(negedge clk); halt_strobe = 0;
    stays_halted("R7", 4);
    irq_req = 3'b000;
    stays_halted("R7", 2);
    irq_req = 3'b001;                          // re-rises, still masked
    stays_halted("R7", 4);
    irq_req = 3'b011;                          // new request on bit 1
    wait_wake("R7", 1, 1, 0);
  endtask

  task automatic t_wdt_wake();
    do_halt("R8");
    @(negedge clk); wdt_ovf = 1;
    wait_wake("R8", 2, 0, 0);
    chk("R8", "timeout set", int'(wdt_timeout_flag), 1);
    chk("R8", "power_down_flag kept", int'(power_down_flag), 1);
    @(negedge clk); wdt_clear = 1; wdt_ovf = 1;
    @(negedge clk); wdt_clear = 0; wdt_ovf = 0;
    chk("R8", "overflow beats clear", int'(wdt_timeout_flag), 1);
  endtask

  task automatic t_priority();
    irq_en = '1; port_wake_en = '1;
    do_halt("R11");
    @(negedge clk); ext_rst = 1; wdt_ovf = 1; irq_req = 3'b001; port_in = 8'hFE;
    wait_wake("R11", 3, 0, 0);
    do_halt("R11");
    @(negedge clk); wdt_ovf = 1; irq_req = 3'b001; port_in = 8'hFE;
    wait_wake("R11", 2, 0, 0);
    do_halt("R11");
    @(negedge clk); irq_req = 3'b001; port_in = 8'hFE;
    wait_wake("R11", 1, 1, 0);
  endtask

  task automatic t_stab_ignore();
    port_wake_en = '1; irq_en = '1;
    do_halt("R12");
    @(negedge clk); port_in = 8'h7F;
    wait_wake("R12", 0, 0, 10);
    chk("R10", "power_down_flag unchanged by late strobe", int'(power_down_flag), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_flags();
    t_port();
    t_irq();
    t_pending();
    t_wdt_wake();
    t_priority();
    t_stab_ignore();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule